// File: doc/BRIEF.md
# Voice Recorder Address Sequencer

This block is the digital control core of a single-chip voice recorder. One 9-bit bus carries either a start location or a mode word, and its two top bits say which. The block samples the bus when the active-low chip enable falls. While a cycle runs, it moves a storage pointer one location per sample tick. The sample tick comes from the master clock, first halved and then divided again, so that one tick falls every 128 master clocks.

In record mode each tick writes the incoming sample to the addressed location. In playback mode each tick reads that location out. When the pointer passes the last location, the block drives an active-low overflow pulse for one tick period and then holds the pointer still. Power-down rewinds the pointer to location zero and stops the tick. Two select outputs steer the speaker path: one chooses the auxiliary input instead of stored audio, and the other enables the speaker driver.

Top module: `vrec_seq`

## Requirements
- R1: When chip_en_n falls and addr_mode[8:7] is not 2'b11, all nine bits of addr_mode become the pointer, and mode_hit goes to 0. Any earlier overflow stop is cleared.
- R2: When chip_en_n falls and addr_mode[8:7] is 2'b11, mode_hit goes to 1 and mode_bits takes addr_mode[6:0]. The pointer keeps its value, so the cycle continues from where the last cycle stopped.
- R3: Changes on addr_mode while chip_en_n stays low have no effect on the pointer.
- R4: sample_stb is a one-clock pulse every 128 clocks. It stays low while pwr_dn is high.
- R5: In a record cycle (chip_en_n low, play_nrec = 0), each strobe writes din to the location at the pointer, and the pointer then advances by one.
- R6: In a playback cycle (play_nrec = 1), each strobe loads dout with the content of the location at the pointer, and the pointer then advances by one.
- R7: On the strobe that acts on location 511, ovf_n goes low and stays low until the next strobe. After that the pointer does not advance, and dout holds its value, until pwr_dn is raised or a new start location is latched.
- R8: While pwr_dn is high, the pointer is reset to 0 and any running cycle and any overflow stop are cleared.
- R9: aux_sel is 1 when chip_en_n is high and play_nrec is 1, or while a playback cycle is stopped by overflow. Otherwise aux_sel is 0.
- R10: spk_en is 0 while pwr_dn is high or play_nrec is 0, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en_n | input | 1 | Active-low enable; its falling edge samples addr_mode |
| pwr_dn | input | 1 | Power-down and pointer rewind |
| play_nrec | input | 1 | 1 selects playback, 0 selects record |
| addr_mode | input | 9 | Shared start-location / mode bus |
| din | input | 8 | Sample to be stored |
| dout | output | 8 | Sample read back |
| sample_stb | output | 1 | Sample-rate strobe |
| ovf_n | output | 1 | Active-low overflow pulse |
| aux_sel | output | 1 | Route the auxiliary input to the speaker path |
| spk_en | output | 1 | Speaker driver enable |
| mode_hit | output | 1 | The last latched bus word was a mode word |
| mode_bits | output | 7 | Mode code from the last mode word |

## Verification
Some rules hold on every cycle, and the assertions check those:
- loading a start location on the enable edge, and holding the pointer on a mode word;
- a single step per strobe, with the pointer frozen after overflow;
- the rewind on power-down;
- writes happening only in record mode;
- the overflow-driven auxiliary select.

Other behaviour can only be shown by the bench's scenarios. These are the data returned after a record-then-play pass, the strobe spacing, and the exact strobe on which the overflow pulse falls and rises. They also include a mode word resuming from a pointer left partway through, and a bus change in mid-cycle having no effect.

// File: rtl/vrec_pkg.sv
package vrec_pkg;

  // Top two bus bits both high mark a mode word instead of a start location.
  function automatic logic bus_is_mode(input logic [1:0] top2);
    return top2 == 2'b11;
  endfunction

  // Master clocks per sample tick: a fixed halving, then HALF_TICKS halved clocks.
  function automatic int unsigned tick_clocks(input int unsigned half_ticks);
    return 2 * half_ticks;
  endfunction

  typedef enum logic {SRC_STORE = 1'b0, SRC_AUX = 1'b1} spk_src_e;

endpackage

// File: rtl/vrec_tick_gen.sv
module vrec_tick_gen #(
  parameter int unsigned HALF_TICKS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  output logic tick
);
  localparam int unsigned CW = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(HALF_TICKS - 1);

  logic          half_ph;
  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap = half_ph && (cnt == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_ph <= 1'b0;
      cnt     <= '0;
      tick    <= 1'b0;
    end else if (hold) begin
      half_ph <= 1'b0;
      cnt     <= '0;
      tick    <= 1'b0;
    end else begin
      half_ph <= ~half_ph;
      tick    <= wrap;
      if (half_ph) cnt <= wrap ? '0 : cnt + CW'(1);
    end
  end

  a_r4_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
  a_r4_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !tick);

endmodule

// File: rtl/vrec_ptr_ctl.sv
module vrec_ptr_ctl
  import vrec_pkg::*;
#(
  parameter int unsigned ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              chip_en_n,
  input  logic              pwr_dn,
  input  logic              play_nrec,
  input  logic [ADDR_W-1:0] addr_mode,
  output logic [ADDR_W-1:0] ptr,
  output logic              mem_we,
  output logic              mem_re,
  output logic              stopped,
  output logic              ovf_n,
  output logic              mode_hit,
  output logic [ADDR_W-3:0] mode_bits
);
  localparam logic [ADDR_W-1:0] PTR_LAST = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] PTR_ONE  = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic ce_q;
  logic ce_fall;
  logic is_mode;
  logic started;
  logic active;
  logic step;
  logic at_top;

  assign ce_fall = ce_q && !chip_en_n;
  assign is_mode = bus_is_mode(addr_mode[ADDR_W-1 -: 2]);
  assign active  = started && !chip_en_n && !pwr_dn && !stopped;
  assign step    = tick && active;
  assign at_top  = (ptr == PTR_LAST);
  assign mem_we  = step && !play_nrec;
  assign mem_re  = step && play_nrec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q      <= 1'b1;
      ptr       <= '0;
      started   <= 1'b0;
      stopped   <= 1'b0;
      ovf_n     <= 1'b1;
      mode_hit  <= 1'b0;
      mode_bits <= '0;
    end else begin
      ce_q <= chip_en_n;
      if (pwr_dn) begin
        ptr     <= '0;
        started <= 1'b0;
        stopped <= 1'b0;
        ovf_n   <= 1'b1;
      end else begin
        if (ce_fall) begin
          started <= 1'b1;
          if (is_mode) begin
            mode_hit  <= 1'b1;
            mode_bits <= addr_mode[ADDR_W-3:0];
          end else begin
            mode_hit <= 1'b0;
            ptr      <= addr_mode;
            stopped  <= 1'b0;
          end
        end else if (chip_en_n) begin
          started <= 1'b0;
        end
        if (tick && !ovf_n) ovf_n <= 1'b1;
        if (step) begin
          if (at_top) begin
            stopped <= 1'b1;
            ovf_n   <= 1'b0;
          end else begin
            ptr <= ptr + PTR_ONE;
          end
        end
      end
    end
  end

  a_r1_addr_load: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_fall && !is_mode && !pwr_dn) |=> (ptr == $past(addr_mode)));
  a_r2_mode_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_fall && is_mode && !pwr_dn && !step) |=> $stable(ptr));
  a_r3_no_midcycle_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_fall && !step && !pwr_dn) |=> $stable(ptr));
  a_r6_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !at_top && !pwr_dn) |=> (ptr == $past(ptr) + PTR_ONE));
  a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && !ce_fall && !pwr_dn) |=> $stable(ptr));
  a_r7_ovf_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovf_n) |-> stopped);
  a_r8_pd_rewind: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> (ptr == '0 && !stopped));

endmodule

// File: rtl/vrec_store.sv
module vrec_store #(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= cells[addr];
  end

  a_r5_no_dual_access: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && re));

endmodule

// File: rtl/vrec_outsel.sv
module vrec_outsel
  import vrec_pkg::*;
(
  input  logic chip_en_n,
  input  logic pwr_dn,
  input  logic play_nrec,
  input  logic stopped,
  output logic aux_sel,
  output logic spk_en
);
  spk_src_e src;

  always_comb begin
    src = SRC_STORE;
    if (play_nrec && (chip_en_n || stopped)) src = SRC_AUX;
  end

  assign aux_sel = (src == SRC_AUX);
  assign spk_en  = play_nrec && !pwr_dn;

endmodule

// File: rtl/vrec_seq.sv
module vrec_seq #(
  parameter int unsigned ADDR_W     = 9,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned HALF_TICKS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_en_n,
  input  logic              pwr_dn,
  input  logic              play_nrec,
  input  logic [ADDR_W-1:0] addr_mode,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              sample_stb,
  output logic              ovf_n,
  output logic              aux_sel,
  output logic              spk_en,
  output logic              mode_hit,
  output logic [ADDR_W-3:0] mode_bits
);
  logic              tick;
  logic [ADDR_W-1:0] ptr;
  logic              mem_we;
  logic              mem_re;
  logic              stopped;

  vrec_tick_gen #(.HALF_TICKS(HALF_TICKS)) u_tick (
    .clk(clk), .rst_n(rst_n), .hold(pwr_dn), .tick(tick)
  );

  vrec_ptr_ctl #(.ADDR_W(ADDR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .tick(tick), .chip_en_n(chip_en_n),
    .pwr_dn(pwr_dn), .play_nrec(play_nrec), .addr_mode(addr_mode),
    .ptr(ptr), .mem_we(mem_we), .mem_re(mem_re), .stopped(stopped),
    .ovf_n(ovf_n), .mode_hit(mode_hit), .mode_bits(mode_bits)
  );

  vrec_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .re(mem_re), .addr(ptr),
    .wdata(din), .rdata(dout)
  );

  vrec_outsel u_out (
    .chip_en_n(chip_en_n), .pwr_dn(pwr_dn), .play_nrec(play_nrec),
    .stopped(stopped), .aux_sel(aux_sel), .spk_en(spk_en)
  );

  assign sample_stb = tick;

  a_r5_write_only_record: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !play_nrec);
  a_r9_aux_after_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && play_nrec) |-> aux_sel);
  a_r10_spk_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_dn || !play_nrec) |-> !spk_en);

endmodule

// File: tb/vrec_seq_bench.sv
module vrec_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       chip_en_n = 1'b1;
  logic       pwr_dn = 1'b0;
  logic       play_nrec = 1'b1;
  logic [8:0] addr_mode = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic       sample_stb, ovf_n, aux_sel, spk_en, mode_hit;
  logic [6:0] mode_bits;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  vrec_seq u_vrec_seq (
    .clk(clk), .rst_n(rst_n), .chip_en_n(chip_en_n), .pwr_dn(pwr_dn),
    .play_nrec(play_nrec), .addr_mode(addr_mode), .din(din), .dout(dout),
    .sample_stb(sample_stb), .ovf_n(ovf_n), .aux_sel(aux_sel),
    .spk_en(spk_en), .mode_hit(mode_hit), .mode_bits(mode_bits)
  );

  function automatic logic [7:0] pat(input int seed, input int k);
    return 8'((seed * 37) + (k * 7) + 3);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Returns at the negedge after the edge on which the strobe acted.
  task automatic wait_stb();
    int n = 0;
    @(negedge clk);
    while (!sample_stb && n < 400) begin @(negedge clk); n++; end
    if (!sample_stb) check("R4 strobe timeout", 0, 1);
    @(negedge clk);
  endtask

  task automatic start_cycle(input logic [8:0] bus, input logic play);
    play_nrec = play;
    addr_mode = bus;
    wait_stb();
    chip_en_n = 1'b0;
  endtask

  task automatic end_cycle();
    @(negedge clk);
    chip_en_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic record(input logic [8:0] bus, input int n, input int seed, input bit wiggle);
    start_cycle(bus, 1'b0);
    for (int k = 0; k < n; k++) begin
      din = pat(seed, k);
      if (wiggle && k == 2) addr_mode = 9'h055;   // R3: mid-cycle bus change
      wait_stb();
    end
    end_cycle();
  endtask

  task automatic play_check(input logic [8:0] bus, input int n, input int seed, input int first);
    start_cycle(bus, 1'b1);
    for (int k = 0; k < n; k++) begin
      wait_stb();
      check("R6 playback data", dout, pat(seed, first + k));
    end
    end_cycle();
  endtask

  task automatic t_reset();
    check("R7 reset ovf_n", ovf_n, 1);
    check("R4 reset strobe", sample_stb, 0);
    check("R2 reset mode_hit", mode_hit, 0);
    check("R6 reset dout", dout, 0);
  endtask

  task automatic t_period();
    int cnt = 0;
    wait_stb();
    do begin @(negedge clk); cnt++; end while (!sample_stb && cnt < 400);
    check("R4 strobe period", cnt + 1, 128);
  endtask

  task automatic t_record_play();
    record(9'd10, 8, 1, 1'b0);     // R5
    play_check(9'd10, 8, 1, 0);    // R6
    record(9'd40, 6, 2, 1'b1);     // R3
    play_check(9'd40, 6, 2, 0);    // R3 data stayed sequential
  endtask

  task automatic t_mode_word();
    record(9'h020, 8, 3, 1'b0);
    play_check(9'h020, 4, 3, 0);
    start_cycle(9'h1AA, 1'b1);
    @(negedge clk); @(negedge clk);
    check("R2 mode_hit set", mode_hit, 1);
    check("R2 mode_bits", mode_bits, 7'h2A);
    wait_stb();
    check("R2 resume from pointer", dout, pat(3, 4));
    end_cycle();
    start_cycle(9'h020, 1'b1);
    @(negedge clk); @(negedge clk);
    check("R1 address clears mode_hit", mode_hit, 0);
    wait_stb();
    check("R1 start location", dout, pat(3, 0));
    end_cycle();
  endtask

  task automatic t_power_down();
    bit seen = 0;
    record(9'd0, 4, 4, 1'b0);
    @(negedge clk);
    pwr_dn = 1'b1;
    for (int i = 0; i < 300; i++) begin @(negedge clk); if (sample_stb) seen = 1; end
    check("R4 no strobe in power-down", seen, 0);
    check("R10 spk_en off in power-down", spk_en, 0);
    pwr_dn = 1'b0;
    start_cycle(9'h180, 1'b1);
    wait_stb();
    check("R8 rewind to zero", dout, pat(4, 0));
    end_cycle();
  endtask

  task automatic t_select();
    @(negedge clk);
    play_nrec = 1'b1; chip_en_n = 1'b1;
    @(negedge clk);
    check("R9 aux when idle play", aux_sel, 1);
    check("R10 spk_en in play", spk_en, 1);
    play_nrec = 1'b0;
    @(negedge clk);
    check("R9 no aux in record", aux_sel, 0);
    check("R10 spk_en off in record", spk_en, 0);
    start_cycle(9'd10, 1'b1);
    @(negedge clk); @(negedge clk);
    check("R9 no aux while playing", aux_sel, 0);
    end_cycle();
  endtask

  task automatic t_overflow();
    start_cycle(9'd383, 1'b0);
    for (int k = 0; k < 129; k++) begin
      din = pat(5, k);
      wait_stb();
      if (k == 127 || k == 128) check("R7 record ovf_n", ovf_n, (k == 128) ? 0 : 1);
    end
    wait_stb();
    check("R7 ovf pulse ends", ovf_n, 1);
    end_cycle();
    start_cycle(9'd383, 1'b1);
    for (int k = 0; k < 129; k++) begin
      wait_stb();
      if (dout != pat(5, k)) check("R5 top region data", dout, pat(5, k));
      if (k == 128) check("R7 playback ovf_n low", ovf_n, 0);
    end
    check("R5 last location data", dout, pat(5, 128));
    check("R9 aux after overflow", aux_sel, 1);
    wait_stb();
    check("R7 stopped holds dout", dout, pat(5, 128));
    check("R7 ovf_n back high", ovf_n, 1);
    end_cycle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_period();
    t_record_play();
    t_mode_word();
    t_power_down();
    t_select();
    t_overflow();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule